// File: doc/BRIEF.md
# Load Retire Station Manager

This block keeps a small pool of physical retire stations that hold the results of loads still in flight. A load arrives on the issue port with a short logical tag, an address and a countdown value. The block binds the tag to a free physical station through a rename-style map, sends a memory request carrying the station number, and captures the response into that station. The load leaves the pool in one of two ways. Either its countdown runs out, or a pickup on the same tag asks for it. Either way, one result appears on the retire port, carrying the tag, the data and a not-a-result flag.

Protection errors from memory do not interrupt anything at issue time. They travel with the station and are reported as the not-a-result flag when the load retires. Programming mistakes are reported at once on separate fault outputs:
- issuing a tag that is already live;
- picking up a tag that is not live;
- issuing when no station is available.

Each station watches a store snoop port. A store that hits a station whose data has already arrived makes that station fetch its data again before it may retire. A pickup with the discard flag set drops a pending load without producing a result. A frame-clear input releases every tag and station at once. The tag count equals the station count and must be a power of two.

Top module: `lrs_manager`

## Requirements
- R1: A load issued with countdown L produces one result with `ret_by_pickup`=0 once L cycles have passed and its data has returned; with data back early, `ret_valid` rises on the clock edge L+1 cycles after the issue edge, never earlier. At most one result leaves per cycle.
- R2: A pickup of a live tag makes the mapped station retire with `ret_by_pickup`=1, as soon as its data is present. A pickup that comes before the data waits for it and does not fault.
- R3: An accepted issue binds its tag to the lowest-numbered free station. It drives `req_valid` in the same cycle with `req_id` equal to that station number, and the result reports the issuing tag.
- R4: Issuing a tag that is still live sets `flt_dup` for one cycle after the issue edge, sends no request, and leaves the existing load intact.
- R5: A pickup of a tag with no live load sets `flt_idle` for one cycle after the pickup edge and produces no result.
- R6: A response with `rsp_err`=1 causes no fault. The load retires with `ret_nar`=1, whether by timeout or by pickup.
- R7: A station is free only when it holds no load and awaits no response. An issue with a non-live tag and no free station sets `flt_full` and sends no request.
- R8: A pickup with `pk_kill`=1 on a live tag frees the station with no result. The tag then counts as not live.
- R9: A store whose address equals that of a station with data present makes the station request its address again. The result then carries the data of the new response. A store to any other address leaves the result unchanged.
- R10: When a pickup arrives in the same cycle in which the station is ready to retire by timeout, the single result reports `ret_by_pickup`=1.
- R11: `clr` releases all tags and stations and suppresses any result in that cycle. Tags are then not live: a pickup faults and a new issue of the same tag is accepted.
- R12: After reset, `ret_valid`, `req_valid` and all three fault outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Frame clear: drop every tag and station |
| iss_valid | input | 1 | Load issue strobe |
| iss_tag | input | TAG_W | Logical tag of the issued load |
| iss_addr | input | ADDR_W | Load address |
| iss_lat | input | CNT_W | Countdown until timeout retire |
| pk_valid | input | 1 | Pickup strobe |
| pk_tag | input | TAG_W | Tag to pick up |
| pk_kill | input | 1 | Discard instead of deliver |
| snp_valid | input | 1 | Store snoop strobe |
| snp_addr | input | ADDR_W | Store address |
| req_valid | output | 1 | Memory request strobe |
| req_id | output | TAG_W | Station number of the request |
| req_addr | output | ADDR_W | Request address |
| rsp_valid | input | 1 | Memory response strobe |
| rsp_id | input | TAG_W | Station number of the response |
| rsp_data | input | DATA_W | Response data |
| rsp_err | input | 1 | Protection error on the response |
| ret_valid | output | 1 | Result strobe |
| ret_tag | output | TAG_W | Tag of the retiring load |
| ret_data | output | DATA_W | Retired data |
| ret_nar | output | 1 | Not-a-result marker |
| ret_by_pickup | output | 1 | 1 for pickup retire, 0 for timeout |
| flt_dup | output | 1 | Fault: issue on a live tag |
| flt_idle | output | 1 | Fault: pickup on a tag with no load |
| flt_full | output | 1 | Fault: no free station |

## Verification
The bench builds the block with four stations, a 4-bit countdown, 12-bit addresses and 16-bit data. Its memory model answers six cycles after each request. Because the response latency is longer than the issue rate, a discarded load can still hold its station while three more loads fill the rest, so the no-free-station fault comes up within a handful of cycles. The same latency leaves a clear window in which a store can hit a station whose data has already arrived, and a zero countdown lets a pickup collide with a timeout in one exact cycle.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    SRC_TIMEOUT = 1'b0,
    SRC_PICKUP  = 1'b1
  } ret_src_e;

endpackage

// File: rtl/lrs_prio.sv
module lrs_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (gnt == '0)) gnt[i] = 1'b1;
    end
  end

  assign any = |req;

endmodule

// File: rtl/lrs_tagmap.sv
module lrs_tagmap #(
  parameter int NUM   = 4,
  parameter int IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      set_en,
  input  logic [IDX_W-1:0]          set_tag,
  input  logic [IDX_W-1:0]          set_st,
  input  logic                      drop_a_en,
  input  logic [IDX_W-1:0]          drop_a_tag,
  input  logic                      drop_b_en,
  input  logic [IDX_W-1:0]          drop_b_tag,
  output logic [NUM-1:0]            live_o,
  output logic [NUM-1:0][IDX_W-1:0] st_o
);

  logic [NUM-1:0]            live_q, live_d;
  logic [NUM-1:0][IDX_W-1:0] st_q, st_d;
  logic                      upd;

  assign upd = clr_all | set_en | drop_a_en | drop_b_en;

  always_comb begin
    live_d = live_q;
    st_d   = st_q;
    if (drop_a_en) live_d[drop_a_tag] = 1'b0;
    if (drop_b_en) live_d[drop_b_tag] = 1'b0;
    if (set_en) begin
      live_d[set_tag] = 1'b1;
      st_d[set_tag]   = set_st;
    end
    if (clr_all) live_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      st_q   <= '0;
    end else if (upd) begin
      live_q <= live_d;
      st_q   <= st_d;
    end
  end

  assign live_o = live_q;
  assign st_o   = st_q;

endmodule

// File: rtl/lrs_station.sv
module lrs_station #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [CNT_W-1:0]  alloc_cnt,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              pick,
  input  logic              kill,
  input  logic              retire,
  input  logic              reissue,
  input  logic              rsp_hit,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              busy,
  output logic              waiting,
  output logic              need_fetch,
  output logic              eligible,
  output logic              picked,
  output logic [TAG_W-1:0]  tag,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              nar
);

  logic              busy_q, busy_d, wait_q, wait_d, ready_q, ready_d;
  logic              stale_q, stale_d, pick_q, pick_d, nar_q, nar_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              fresh, upd;

  assign fresh = rsp_hit & wait_q;
  assign upd   = alloc | clr | busy_q | rsp_hit;

  always_comb begin
    busy_d  = busy_q;  wait_d = wait_q; ready_d = ready_q;
    stale_d = stale_q; pick_d = pick_q; nar_d   = nar_q;
    cnt_d   = cnt_q;   tag_d  = tag_q;  addr_d  = addr_q;
    data_d  = data_q;
    if (fresh) begin
      wait_d = 1'b0;
      if (busy_q) begin
        data_d  = rsp_data;
        nar_d   = rsp_err;
        ready_d = 1'b1;
      end
    end
    if (busy_q) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      if (pick) pick_d = 1'b1;
      if (snp_valid && (snp_addr == addr_q) && (ready_q || fresh)) begin
        stale_d = 1'b1;
        ready_d = 1'b0;
      end
      if (reissue) begin
        stale_d = 1'b0;
        wait_d  = 1'b1;
      end
      if (retire || kill) begin
        busy_d = 1'b0; ready_d = 1'b0; stale_d = 1'b0; pick_d = 1'b0;
      end
    end
    if (clr) begin
      busy_d = 1'b0; ready_d = 1'b0; stale_d = 1'b0; pick_d = 1'b0;
    end
    if (alloc) begin
      busy_d  = 1'b1; wait_d = 1'b1; ready_d = 1'b0;
      stale_d = 1'b0; pick_d = 1'b0;
      cnt_d   = alloc_cnt;
      tag_d   = alloc_tag;
      addr_d  = alloc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wait_q <= 1'b0; ready_q <= 1'b0;
      stale_q <= 1'b0; pick_q <= 1'b0; nar_q <= 1'b0;
      cnt_q <= '0; tag_q <= '0; addr_q <= '0; data_q <= '0;
    end else if (upd) begin
      busy_q <= busy_d; wait_q <= wait_d; ready_q <= ready_d;
      stale_q <= stale_d; pick_q <= pick_d; nar_q <= nar_d;
      cnt_q <= cnt_d; tag_q <= tag_d; addr_q <= addr_d; data_q <= data_d;
    end
  end

  assign busy       = busy_q;
  assign waiting    = wait_q;
  assign need_fetch = busy_q & stale_q & ~wait_q;
  assign eligible   = busy_q & ready_q & (pick_q | (cnt_q == '0));
  assign picked     = pick_q;
  assign tag        = tag_q;
  assign addr       = addr_q;
  assign data       = data_q;
  assign nar        = nar_q;

  // R7: the manager only hands out a station that is idle and awaits nothing
  a_r7_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (!busy_q && !wait_q));

  // R9: a station never leaves while its data is missing or stale
  a_r9_retire_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (ready_q && !stale_q && busy_q));

  // R1: the countdown falls by one per cycle while the load stays
  a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != '0) && !alloc && !clr && !retire && !kill)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: a discard releases the station at the next edge
  a_r8_kill_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !alloc) |=> !busy_q);

endmodule

// File: rtl/lrs_manager.sv
module lrs_manager
  import lrs_pkg::*;
#(
  parameter int NUM_ST = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  localparam int TAG_W = idx_w(NUM_ST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              iss_valid,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [CNT_W-1:0]  iss_lat,
  input  logic              pk_valid,
  input  logic [TAG_W-1:0]  pk_tag,
  input  logic              pk_kill,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              req_valid,
  output logic [TAG_W-1:0]  req_id,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag,
  output logic [DATA_W-1:0] ret_data,
  output logic              ret_nar,
  output logic              ret_by_pickup,
  output logic              flt_dup,
  output logic              flt_idle,
  output logic              flt_full
);

  logic [NUM_ST-1:0]             busy, waiting, need_fetch, eligible, picked;
  logic [NUM_ST-1:0][TAG_W-1:0]  sta_tag;
  logic [NUM_ST-1:0][ADDR_W-1:0] sta_addr;
  logic [NUM_ST-1:0][DATA_W-1:0] sta_data;
  logic [NUM_ST-1:0]             sta_nar;
  logic [NUM_ST-1:0]             live;
  logic [NUM_ST-1:0][TAG_W-1:0]  map_st;

  logic [NUM_ST-1:0] free_vec, free_oh, alloc_vec;
  logic [NUM_ST-1:0] pk_hit, kill_vec, rsp_hit;
  logic [NUM_ST-1:0] cand, urgent, urg_oh, cand_oh, ret_oh;
  logic [NUM_ST-1:0] fetch_oh, reis_vec;
  logic              free_any, urg_any, cand_any, fetch_any;
  logic              iss_live, iss_ok, pk_live, reis_en, ret_any;
  logic [TAG_W-1:0]  pk_station, alloc_idx, ret_idx, fetch_idx;
  ret_src_e          ret_src;

  // ---------------- issue side ----------------
  assign free_vec  = ~busy & ~waiting;
  assign iss_live  = live[iss_tag];
  assign iss_ok    = iss_valid & ~clr & ~iss_live & free_any;
  assign alloc_vec = free_oh & {NUM_ST{iss_ok}};

  lrs_prio #(.N(NUM_ST)) u_free_pick (.req(free_vec), .gnt(free_oh), .any(free_any));

  // ---------------- pickup side ----------------
  assign pk_live    = live[pk_tag];
  assign pk_station = map_st[pk_tag];

  // ---------------- retire and refetch choice ----------------
  assign cand    = eligible & ~kill_vec & {NUM_ST{~clr}};
  assign urgent  = cand & (picked | pk_hit);
  assign ret_oh  = urg_any ? urg_oh : cand_oh;
  assign ret_any = cand_any;
  assign reis_en = fetch_any & ~iss_ok & ~clr;
  assign reis_vec = fetch_oh & {NUM_ST{reis_en}};

  lrs_prio #(.N(NUM_ST)) u_urg_pick   (.req(urgent),     .gnt(urg_oh),   .any(urg_any));
  lrs_prio #(.N(NUM_ST)) u_cand_pick  (.req(cand),       .gnt(cand_oh),  .any(cand_any));
  lrs_prio #(.N(NUM_ST)) u_fetch_pick (.req(need_fetch), .gnt(fetch_oh), .any(fetch_any));

  always_comb begin
    alloc_idx = '0;
    ret_idx   = '0;
    fetch_idx = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (free_oh[i])  alloc_idx = TAG_W'(i);
      if (ret_oh[i])   ret_idx   = TAG_W'(i);
      if (fetch_oh[i]) fetch_idx = TAG_W'(i);
    end
  end

  assign ret_src = (picked[ret_idx] | pk_hit[ret_idx]) ? SRC_PICKUP : SRC_TIMEOUT;

  // ---------------- memory request ----------------
  assign req_valid = iss_ok | reis_en;
  assign req_id    = iss_ok ? alloc_idx : fetch_idx;
  assign req_addr  = iss_ok ? iss_addr : sta_addr[fetch_idx];

  // ---------------- stations ----------------
  for (genvar g = 0; g < NUM_ST; g++) begin : g_st
    assign pk_hit[g]   = pk_valid & ~clr & pk_live & ~pk_kill & (pk_station == TAG_W'(g));
    assign kill_vec[g] = pk_valid & ~clr & pk_live &  pk_kill & (pk_station == TAG_W'(g));
    assign rsp_hit[g]  = rsp_valid & (rsp_id == TAG_W'(g));

    lrs_station #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TAG_W(TAG_W)
    ) u_station (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .alloc      (alloc_vec[g]),
      .alloc_addr (iss_addr),
      .alloc_cnt  (iss_lat),
      .alloc_tag  (iss_tag),
      .pick       (pk_hit[g]),
      .kill       (kill_vec[g]),
      .retire     (ret_oh[g]),
      .reissue    (reis_vec[g]),
      .rsp_hit    (rsp_hit[g]),
      .rsp_data   (rsp_data),
      .rsp_err    (rsp_err),
      .snp_valid  (snp_valid),
      .snp_addr   (snp_addr),
      .busy       (busy[g]),
      .waiting    (waiting[g]),
      .need_fetch (need_fetch[g]),
      .eligible   (eligible[g]),
      .picked     (picked[g]),
      .tag        (sta_tag[g]),
      .addr       (sta_addr[g]),
      .data       (sta_data[g]),
      .nar        (sta_nar[g])
    );
  end

  // ---------------- tag rename table ----------------
  lrs_tagmap #(.NUM(NUM_ST), .IDX_W(TAG_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr),
    .set_en     (iss_ok),
    .set_tag    (iss_tag),
    .set_st     (alloc_idx),
    .drop_a_en  (ret_any),
    .drop_a_tag (sta_tag[ret_idx]),
    .drop_b_en  (|kill_vec),
    .drop_b_tag (pk_tag),
    .live_o     (live),
    .st_o       (map_st)
  );

  // ---------------- registered outputs ----------------
  logic              ret_v_d, ret_nar_d, ret_bp_d, fd_d, fi_d, ff_d;
  logic [TAG_W-1:0]  ret_tag_d;
  logic [DATA_W-1:0] ret_data_d;

  always_comb begin
    ret_v_d    = ret_any;
    ret_tag_d  = sta_tag[ret_idx];
    ret_data_d = sta_data[ret_idx];
    ret_nar_d  = sta_nar[ret_idx];
    ret_bp_d   = (ret_src == SRC_PICKUP);
    fd_d       = iss_valid & ~clr & iss_live;
    ff_d       = iss_valid & ~clr & ~iss_live & ~free_any;
    fi_d       = pk_valid & ~clr & ~pk_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid <= 1'b0; ret_tag <= '0; ret_data <= '0;
      ret_nar <= 1'b0; ret_by_pickup <= 1'b0;
      flt_dup <= 1'b0; flt_idle <= 1'b0; flt_full <= 1'b0;
    end else begin
      ret_valid <= ret_v_d;
      flt_dup   <= fd_d;
      flt_idle  <= fi_d;
      flt_full  <= ff_d;
      if (ret_v_d) begin
        ret_tag       <= ret_tag_d;
        ret_data      <= ret_data_d;
        ret_nar       <= ret_nar_d;
        ret_by_pickup <= ret_bp_d;
      end
    end
  end

  // ---------------- assertions ----------------
  // R1: no more than one station leaves per cycle
  a_r1_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ret_oh));

  // R3: every live tag points at a station that holds a load
  for (genvar t = 0; t < NUM_ST; t++) begin : g_mapchk
    a_r3_map_busy: assert property (@(posedge clk) disable iff (!rst_n)
      live[t] |-> busy[map_st[t]]);
  end

  // R4: a rejected duplicate issue does not move the tag's binding
  a_r4_dup_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !clr && iss_live && !ret_any && !(|kill_vec))
      |=> (live[$past(iss_tag)] && (map_st[$past(iss_tag)] == $past(map_st[iss_tag]))));

  // R11: a frame clear leaves no live tag and no result
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((live == '0) && !ret_valid));

endmodule

// File: tb/tb_lrs_manager.sv
module tb_lrs_manager;

  localparam int NS = 4;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int TW = 2;
  localparam int MEM_DLY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic iss_valid = 1'b0;
  logic [TW-1:0] iss_tag = '0;
  logic [AW-1:0] iss_addr = '0;
  logic [CW-1:0] iss_lat = '0;
  logic pk_valid = 1'b0;
  logic [TW-1:0] pk_tag = '0;
  logic pk_kill = 1'b0;
  logic snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic req_valid;
  logic [TW-1:0] req_id;
  logic [AW-1:0] req_addr;
  logic rsp_valid;
  logic [TW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;
  logic rsp_err;
  logic ret_valid, ret_nar, ret_by_pickup;
  logic [TW-1:0] ret_tag;
  logic [DW-1:0] ret_data;
  logic flt_dup, flt_idle, flt_full;

  always #5 clk = ~clk;

  lrs_manager #(.NUM_ST(NS), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_addr(iss_addr), .iss_lat(iss_lat),
    .pk_valid(pk_valid), .pk_tag(pk_tag), .pk_kill(pk_kill),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data), .ret_nar(ret_nar),
    .ret_by_pickup(ret_by_pickup),
    .flt_dup(flt_dup), .flt_idle(flt_idle), .flt_full(flt_full)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] ver [256];

  function automatic logic [DW-1:0] mk(input logic [AW-1:0] a);
    return {a[7:0], ver[a[7:0]]};
  endfunction

  typedef struct packed {
    logic          v;
    logic [TW-1:0] id;
    logic [DW-1:0] d;
    logic          e;
  } mem_t;

  mem_t pipe [MEM_DLY];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MEM_DLY; k++) pipe[k] <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      for (int k = MEM_DLY - 1; k > 0; k--) pipe[k] <= pipe[k-1];
      pipe[0]   <= '{v: req_valid, id: req_id, d: mk(req_addr), e: req_addr[AW-1]};
      rsp_valid <= pipe[MEM_DLY-1].v;
      rsp_id    <= pipe[MEM_DLY-1].id;
      rsp_data  <= pipe[MEM_DLY-1].d;
      rsp_err   <= pipe[MEM_DLY-1].e;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int tag;
    int data;
    bit nar;
    bit bp;
    string rq;
  } exp_t;

  exp_t exp_q[$];

  task automatic expect_ret(input int tag, input logic [AW-1:0] a, input bit bp, input string rq);
    exp_t e;
    e.tag = tag; e.data = int'(mk(a)); e.nar = a[AW-1]; e.bp = bp; e.rq = rq;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8/R11 unexpected result, tag", int'(ret_tag), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(ret_tag) == e.tag, {e.rq, " result tag"}, int'(ret_tag), e.tag);
        chk(int'(ret_data) == e.data, {e.rq, " result data"}, int'(ret_data), e.data);
        chk(ret_nar == e.nar, {e.rq, " result nar"}, int'(ret_nar), int'(e.nar));
        chk(ret_by_pickup == e.bp, {e.rq, " result source"}, int'(ret_by_pickup), int'(e.bp));
      end
    end
  end

  // ---------------- drivers ----------------
  logic s_req_v, s_dup, s_idle, s_full;
  logic [TW-1:0] s_req_id;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_issue(input int tag, input logic [AW-1:0] a, input int lat);
    iss_valid = 1'b1; iss_tag = TW'(tag); iss_addr = a; iss_lat = CW'(lat);
    #1;
    s_req_v = req_valid; s_req_id = req_id;
    @(negedge clk);
    s_dup = flt_dup; s_idle = flt_idle; s_full = flt_full;
    iss_valid = 1'b0;
  endtask

  task automatic do_pick(input int tag, input bit kill);
    pk_valid = 1'b1; pk_tag = TW'(tag); pk_kill = kill;
    @(negedge clk);
    s_dup = flt_dup; s_idle = flt_idle; s_full = flt_full;
    pk_valid = 1'b0; pk_kill = 1'b0;
  endtask

  task automatic do_store(input logic [AW-1:0] a);
    ver[a[7:0]] = ver[a[7:0]] + 8'd1;
    snp_valid = 1'b1; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic drain(input int n, input string rq);
    tick(n);
    chk(exp_q.size() == 0, {rq, " pending results after drain"}, exp_q.size(), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int k = 0; k < 256; k++) ver[k] = 8'd0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R12 reset state
    chk(ret_valid == 1'b0, "R12 ret_valid after reset", int'(ret_valid), 0);
    chk(req_valid == 1'b0, "R12 req_valid after reset", int'(req_valid), 0);
    chk({flt_dup, flt_idle, flt_full} == 3'b000, "R12 faults after reset",
        int'({flt_dup, flt_idle, flt_full}), 0);

    // R1 + R3: timeout retire, exact cycle; R9 unrelated store ignored
    do_issue(2, 12'h010, 12);
    chk(s_req_v && s_req_id == 2'd0, "R3 request on lowest free station", int'(s_req_id), 0);
    chk({s_dup, s_idle, s_full} == 3'b000, "R1 no fault on clean issue",
        int'({s_dup, s_idle, s_full}), 0);
    expect_ret(2, 12'h010, 1'b0, "R1");
    tick(4);
    do_store(12'h099);
    tick(7);
    chk(ret_valid == 1'b0, "R1 no result before countdown ends", int'(ret_valid), 0);
    tick(1);
    chk(ret_valid == 1'b1, "R1 result at countdown end", int'(ret_valid), 1);
    drain(3, "R1");

    // R2: pickup after data present
    do_issue(1, 12'h030, 15);
    expect_ret(1, 12'h030, 1'b1, "R2");
    tick(9);
    do_pick(1, 1'b0);
    chk(s_idle == 1'b0, "R2 pickup of live tag no fault", int'(s_idle), 0);
    drain(4, "R2");

    // R2: pickup before data arrives waits for it
    do_issue(3, 12'h040, 15);
    expect_ret(3, 12'h040, 1'b1, "R2");
    do_pick(3, 1'b0);
    chk(s_idle == 1'b0, "R2 early pickup no fault", int'(s_idle), 0);
    drain(12, "R2");

    // R6: protection error by timeout and by pickup
    do_issue(0, 12'h800, 3);
    chk({s_dup, s_idle, s_full} == 3'b000, "R6 no fault at issue",
        int'({s_dup, s_idle, s_full}), 0);
    expect_ret(0, 12'h800, 1'b0, "R6");
    drain(12, "R6");
    do_issue(1, 12'h810, 15);
    expect_ret(1, 12'h810, 1'b1, "R6");
    do_pick(1, 1'b0);
    drain(12, "R6");

    // R4 duplicate issue, R8 discard
    do_issue(0, 12'h050, 15);
    do_issue(0, 12'h060, 15);
    chk(s_dup == 1'b1, "R4 duplicate tag fault", int'(s_dup), 1);
    chk(s_req_v == 1'b0, "R4 duplicate sends no request", int'(s_req_v), 0);
    do_pick(0, 1'b1);
    chk(s_idle == 1'b0, "R8 discard of live tag no fault", int'(s_idle), 0);
    do_pick(0, 1'b0);
    chk(s_idle == 1'b1, "R8 tag not live after discard", int'(s_idle), 1);
    drain(20, "R8");

    // R5 pickup of idle tag
    do_pick(3, 1'b0);
    chk(s_idle == 1'b1, "R5 pickup of idle tag faults", int'(s_idle), 1);
    drain(3, "R5");

    // R7 no station free: discarded load still awaits its response
    do_issue(0, 12'h070, 15);
    do_pick(0, 1'b1);
    do_issue(1, 12'h071, 15);
    do_issue(2, 12'h072, 15);
    do_issue(3, 12'h073, 15);
    chk(s_full == 1'b0, "R7 last free station accepted", int'(s_full), 0);
    do_issue(0, 12'h074, 15);
    chk(s_full == 1'b1, "R7 no free station fault", int'(s_full), 1);
    chk(s_req_v == 1'b0, "R7 no request when full", int'(s_req_v), 0);
    do_pick(1, 1'b1);
    do_pick(2, 1'b1);
    do_pick(3, 1'b1);
    drain(15, "R7");

    // R9 aliasing store forces a refetch
    do_issue(1, 12'h0A0, 15);
    tick(9);
    do_store(12'h0A0);
    expect_ret(1, 12'h0A0, 1'b0, "R9");
    drain(25, "R9");

    // R10 pickup in the same cycle as timeout eligibility
    do_issue(2, 12'h0B0, 0);
    expect_ret(2, 12'h0B0, 1'b1, "R10");
    while (!rsp_valid) tick(1);
    tick(1);
    do_pick(2, 1'b0);
    chk(s_idle == 1'b0, "R10 colliding pickup no fault", int'(s_idle), 0);
    drain(5, "R10");

    // R11 frame clear
    do_issue(0, 12'h0C0, 15);
    do_issue(1, 12'h0D0, 15);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    do_pick(0, 1'b0);
    chk(s_idle == 1'b1, "R11 tag not live after clear", int'(s_idle), 1);
    do_issue(0, 12'h0E0, 4);
    chk(s_dup == 1'b0 && s_req_v == 1'b1, "R11 tag reusable after clear",
        int'({s_dup, s_req_v}), 1);
    expect_ret(0, 12'h0E0, 1'b0, "R11");
    drain(25, "R11");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule